// File: doc/BRIEF.md
# Row-to-Lane Binary Serializer with Frame Markers

This block turns each 128-column row of binary hit flags into sixteen serial lanes. Each lane sends eight bits per row. Before a row is stored, the block chooses its source: the live hit flags, or a programmable 128-bit test line. It then clears every column whose disable bit is set. The stored row waits in a holding register while the previous row is still being shifted out, so rows handed over every 16 main-clock cycles are sent back to back with no gap.

Each lane shifts one bit every two main-clock cycles. The block also drives a half-rate digital clock, and new data appear on each falling edge of that clock. Two sync markers, one for the analogue path and one for the digital path, help the acquisition system align frames. An enable input arms them during one frame, and they take effect in the following frame. A mode input selects how they behave. In pulse mode they flag the last row and the last bit of the frame. In clock mode they are gated copies of the analogue sampling clock and of the digital clock.

Top module: `row_lane_serializer`

## Requirements
- R1: Lane k (k = 0..15) carries columns 8k+7 down to 8k of a row. The highest of these columns is sent first, and the lowest is sent last.
- R2: While a row is being shifted, `dclk` is low for the first main-clock cycle of each bit and high for the second. Lane data change only at the start of a bit, which is a falling edge of `dclk`.
- R3: A column whose bit in `col_off` is 1 is sent as 0, whatever its source.
- R4: When `pat_all` is 1 at the handover, `test_line` replaces the hit flags of that row.
- R5: When `xrow_en` and `row_xtra` are both 1 at the handover, that appended row sends `test_line`. When `row_xtra` is 1 but `xrow_en` is 0, the row sends its hit flags.
- R6: A row handed over with `row_stb` appears on the lanes from the second clock edge after the handover. The row it replaces is still sent in full. Rows handed over every 16 cycles are sent with no gap.
- R7: The value of `sync_en` at the handover of a frame's last row (the one with `row_end` = 1) arms or disarms both markers for the whole next frame. A disarmed frame and the first frame after reset keep both markers at 0.
- R8: With `sync_mode` = 0 in an armed frame, `mk_ana` is 1 for the whole 16-cycle slot of the frame's last row. `mk_dig` is 1 only during the last bit (2 cycles) of that row.
- R9: With `sync_mode` = 1 in an armed frame, `mk_ana` follows `samp_clk` while a row is being sent, and `mk_dig` follows `dclk`.
- R10: After reset, and whenever no row is being sent, `dout`, `dclk`, `mk_ana` and `mk_dig` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| row_stb | input | 1 | One-cycle handover of a row |
| row_bits | input | 128 | Hit flags of the row, one per column |
| row_end | input | 1 | Row is the last one of its frame |
| row_xtra | input | 1 | Row is an appended marker row |
| col_off | input | 128 | Column disable mask (1 forces 0) |
| test_line | input | 128 | Programmable test line |
| pat_all | input | 1 | Test line replaces every row |
| xrow_en | input | 1 | Appended rows carry the test line |
| sync_en | input | 1 | Arms the markers for the next frame |
| sync_mode | input | 1 | 0: last-row/last-bit pulses, 1: gated clocks |
| samp_clk | input | 1 | Analogue sampling clock to copy in clock mode |
| dout | output | 16 | Serial lanes |
| dclk | output | 1 | Half-rate digital clock |
| mk_ana | output | 1 | Analogue sync marker |
| mk_dig | output | 1 | Digital sync marker |

## Verification
The hardest case to reach is the marker hand-off at a frame boundary. The enable value captured with one frame's last row must switch the markers exactly at the first bit of the next frame. Meanwhile the last row of the current frame is still being shifted, and its own last-bit pulse depends on the older setting. The stimulus sends several frames back to back with no idle gap. The enable pattern is chosen per frame (armed, disarmed, armed again), and some frames are lengthened by appended rows. This lines up every combination of old and new setting at the boundary, in both marker modes. Random masks, including all-ones masks, and random source selection run alongside.

// File: rtl/rls_pkg.sv
// Shared types and helpers for the row-to-lane serializer.
package rls_pkg;
    typedef enum logic {
        MK_PULSE = 1'b0,
        MK_CLOCK = 1'b1
    } mk_mode_e;

    // Row slot length in main-clock cycles: two cycles per serial bit.
    function automatic int unsigned slot_len(input int unsigned bits_per_lane);
        return 2 * bits_per_lane;
    endfunction
endpackage

// File: rtl/row_source_select.sv
// Chooses the source of a row (hit flags or test line) and clears disabled
// columns. Purely combinational; assumes all inputs are stable at handover.
module row_source_select #(
    parameter int NCOLS = 128
) (
    input  logic             pat_all,
    input  logic             xrow_en,
    input  logic             row_xtra,
    input  logic [NCOLS-1:0] row_bits,
    input  logic [NCOLS-1:0] test_line,
    input  logic [NCOLS-1:0] col_off,
    output logic [NCOLS-1:0] prepped
);
    logic use_line;

    // Source choice followed by the column mask.
    always_comb begin
        use_line = pat_all | (xrow_en & row_xtra);
        prepped  = (use_line ? test_line : row_bits) & ~col_off;
    end
endmodule

// File: rtl/row_hold_buffer.sv
// Second stage of the double buffer: holds one prepared row until the
// serializer takes it. Assumes at most one handover per row slot.
module row_hold_buffer #(
    parameter int NCOLS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             take,
    input  logic [NCOLS-1:0] din,
    input  logic             din_end,
    input  logic [NCOLS-1:0] col_off,
    output logic [NCOLS-1:0] hold_q,
    output logic             hold_end,
    output logic             hold_full
);
    // Capture a new row; clear the full flag once the serializer takes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_end  <= 1'b0;
            hold_full <= 1'b0;
        end else if (load) begin
            hold_q    <= din;
            hold_end  <= din_end;
            hold_full <= 1'b1;
        end else if (take) begin
            hold_full <= 1'b0;
        end
    end

    p_mask_applied_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ((hold_q & $past(col_off)) == '0));
endmodule

// File: rtl/lane_serializer.sv
// Shift stage: takes a held row at the end of the current slot (or at once
// when idle) and sends it on LANES lanes, highest column of each lane first,
// one bit per two clock cycles. Drives the half-rate digital clock.
module lane_serializer #(
    parameter int NCOLS = 128,
    parameter int LANES = 16
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NCOLS-1:0]                      hold_q,
    input  logic                                  hold_end,
    input  logic                                  hold_full,
    output logic                                  take,
    output logic                                  active,
    output logic [$clog2(NCOLS/LANES)-1:0]        bit_idx,
    output logic                                  sh_end,
    output logic [LANES-1:0]                      dout,
    output logic                                  dclk
);
    localparam int BPL  = NCOLS / LANES;
    localparam int SLOT = rls_pkg::slot_len(BPL);
    localparam int CW   = $clog2(SLOT);
    localparam int BW   = $clog2(BPL);
    localparam logic [CW-1:0] LAST_CNT = CW'(SLOT - 1);
    localparam logic [BW-1:0] TOP_BIT  = BW'(BPL - 1);

    logic [NCOLS-1:0] sh_q;
    logic [CW-1:0]    cnt;

    // Handover point: free serializer or last cycle of the current slot.
    always_comb begin
        take    = hold_full && (!active || (cnt == LAST_CNT));
        bit_idx = cnt[CW-1:1];
        dclk    = active & cnt[0];
    end

    // Slot counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            sh_end <= 1'b0;
            cnt    <= '0;
            active <= 1'b0;
        end else if (take) begin
            sh_q   <= hold_q;
            sh_end <= hold_end;
            cnt    <= '0;
            active <= 1'b1;
        end else if (active) begin
            if (cnt == LAST_CNT) begin
                active <= 1'b0;
                cnt    <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Per-lane bit pick, most significant column first.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [BPL-1:0] lane_bits;
        always_comb begin
            lane_bits = sh_q[k*BPL +: BPL];
            dout[k]   = active & lane_bits[TOP_BIT - bit_idx];
        end
    end

    p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt[0]) |-> $stable(dout));
    p_clk_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active)) |-> (dclk != $past(dclk)));
endmodule

// File: rtl/marker_gen.sv
// Sync markers. The enable seen with a frame's last row is applied from the
// first row of the next frame. Mode picks pulses or gated clocks.
module marker_gen #(
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          row_stb,
    input  logic          row_end,
    input  logic          sync_en,
    input  logic          sync_mode,
    input  logic          samp_clk,
    input  logic          take,
    input  logic          active,
    input  logic          sh_end,
    input  logic [BW-1:0] bit_idx,
    input  logic          dclk,
    output logic          mk_ana,
    output logic          mk_dig
);
    import rls_pkg::*;

    logic     arm_req;
    logic     arm_q;
    mk_mode_e mode;

    // Request captured with the frame's last row; applied at the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_req <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            if (row_stb && row_end)
                arm_req <= sync_en;
            if (take && sh_end)
                arm_q <= arm_req;
        end
    end

    // Marker shape per mode.
    always_comb begin
        mode = mk_mode_e'(sync_mode);
        if (mode == MK_PULSE) begin
            mk_ana = arm_q & active & sh_end;
            mk_dig = arm_q & active & sh_end & (&bit_idx);
        end else begin
            mk_ana = arm_q & active & samp_clk;
            mk_dig = arm_q & dclk;
        end
    end

    p_disarm_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && sh_end && !arm_req) |=> (!mk_ana && !mk_dig));
endmodule

// File: rtl/row_lane_serializer.sv
// Top: source select and mask, hold register, lane shifter, markers.
// Assumes row handovers come at most once per 16-cycle slot.
module row_lane_serializer #(
    parameter int NCOLS = 128,
    parameter int LANES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             row_stb,
    input  logic [NCOLS-1:0] row_bits,
    input  logic             row_end,
    input  logic             row_xtra,
    input  logic [NCOLS-1:0] col_off,
    input  logic [NCOLS-1:0] test_line,
    input  logic             pat_all,
    input  logic             xrow_en,
    input  logic             sync_en,
    input  logic             sync_mode,
    input  logic             samp_clk,
    output logic [LANES-1:0] dout,
    output logic             dclk,
    output logic             mk_ana,
    output logic             mk_dig
);
    localparam int BW = $clog2(NCOLS / LANES);

    logic [NCOLS-1:0] prepped;
    logic [NCOLS-1:0] hold_q;
    logic             hold_end;
    logic             hold_full;
    logic             take;
    logic             active;
    logic [BW-1:0]    bit_idx;
    logic             sh_end;

    row_source_select #(.NCOLS(NCOLS)) u_sel (
        .pat_all(pat_all), .xrow_en(xrow_en), .row_xtra(row_xtra),
        .row_bits(row_bits), .test_line(test_line), .col_off(col_off),
        .prepped(prepped)
    );

    row_hold_buffer #(.NCOLS(NCOLS)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(row_stb), .take(take),
        .din(prepped), .din_end(row_end), .col_off(col_off),
        .hold_q(hold_q), .hold_end(hold_end), .hold_full(hold_full)
    );

    lane_serializer #(.NCOLS(NCOLS), .LANES(LANES)) u_ser (
        .clk(clk), .rst_n(rst_n), .hold_q(hold_q), .hold_end(hold_end),
        .hold_full(hold_full), .take(take), .active(active),
        .bit_idx(bit_idx), .sh_end(sh_end), .dout(dout), .dclk(dclk)
    );

    marker_gen #(.BW(BW)) u_mk (
        .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .row_end(row_end),
        .sync_en(sync_en), .sync_mode(sync_mode), .samp_clk(samp_clk),
        .take(take), .active(active), .sh_end(sh_end), .bit_idx(bit_idx),
        .dclk(dclk), .mk_ana(mk_ana), .mk_dig(mk_dig)
    );

    p_pulse_nested_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && mk_dig) |-> mk_ana);
    p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode && $past(!sync_mode) && $rose(mk_dig)) |=> mk_dig);
    p_clock_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && mk_dig) |-> dclk);
endmodule

// File: tb/row_lane_serializer_bench.sv
`timescale 1ns/1ps
module row_lane_serializer_bench;
    localparam int NC = 128;
    localparam int NL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_stb = 1'b0, row_end = 1'b0, row_xtra = 1'b0;
    logic [NC-1:0] row_bits = '0, col_off = '0, test_line = '0;
    logic pat_all = 1'b0, xrow_en = 1'b0, sync_en = 1'b0, sync_mode = 1'b0, samp_clk = 1'b0;
    logic [NL-1:0] dout;
    logic dclk, mk_ana, mk_dig;

    int n_chk = 0;
    int n_fail = 0;

    logic [NC-1:0] d_bits[64], d_off[64], d_line[64], e_row[64];
    bit d_po[64], d_lm[64], d_xtra[64], d_end[64], d_spk[64], e_en[64];

    always #2.5 clk = ~clk;

    row_lane_serializer u_row_lane_serializer (
        .clk(clk), .rst_n(rst_n), .row_stb(row_stb), .row_bits(row_bits),
        .row_end(row_end), .row_xtra(row_xtra), .col_off(col_off),
        .test_line(test_line), .pat_all(pat_all), .xrow_en(xrow_en),
        .sync_en(sync_en), .sync_mode(sync_mode), .samp_clk(samp_clk),
        .dout(dout), .dclk(dclk), .mk_ana(mk_ana), .mk_dig(mk_dig)
    );

    function automatic logic [NC-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Expected lane word for a row at slot cycle c (R1: lane k, MSB first).
    function automatic logic [NL-1:0] lanes_of(input logic [NC-1:0] r, input int c);
        logic [NL-1:0] v;
        for (int k = 0; k < NL; k++) v[k] = r[8*k + 7 - c/2];
        return v;
    endfunction

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(dout == '0, {tag, " R10 dout idle"}, 32'(dout), 0);
        chk(dclk == 1'b0, {tag, " R10 dclk idle"}, 32'(dclk), 0);
        chk(mk_ana == 1'b0, {tag, " R10 mk_ana idle"}, 32'(mk_ana), 0);
        chk(mk_dig == 1'b0, {tag, " R10 mk_dig idle"}, 32'(mk_dig), 0);
    endtask

    task automatic check_row(input int r, input int c, input bit mode);
        logic [NL-1:0] ed;
        bit ea, eg;
        ed = lanes_of(e_row[r], c);
        chk(dout == ed, "R1 R3 R4 R5 R6 lane data", 32'(dout), 32'(ed));
        chk(dclk == 1'(c % 2), "R2 dclk phase", 32'(dclk), 32'(c % 2));
        if (!mode) begin
            ea = e_en[r] && d_end[r];
            eg = ea && (c >= 14);
            chk(mk_ana == ea, "R7 R8 mk_ana pulse", 32'(mk_ana), 32'(ea));
            chk(mk_dig == eg, "R7 R8 mk_dig last bit", 32'(mk_dig), 32'(eg));
        end else begin
            ea = e_en[r] && samp_clk;
            eg = e_en[r] && (c % 2 == 1);
            chk(mk_ana == ea, "R7 R9 mk_ana clock", 32'(mk_ana), 32'(ea));
            chk(mk_dig == eg, "R7 R9 mk_dig clock", 32'(mk_dig), 32'(eg));
        end
    endtask

    // One run: reset, then frames back to back; per-frame enable/source bits.
    task automatic run(input bit mode, input int nfr, input bit [7:0] spk, input bit [7:0] po, input bit [7:0] lm);
        int n = 0;
        for (int f = 0; f < nfr; f++) begin
            int rows = lm[f] ? 6 : 4;
            for (int r = 0; r < rows; r++) begin
                int sel = $urandom % 4;
                d_bits[n] = rnd128();
                d_line[n] = rnd128();
                d_off[n]  = (sel == 0) ? '1 : (sel == 1) ? '0 : (rnd128() & rnd128());
                d_po[n]   = po[f];
                d_lm[n]   = lm[f];
                d_xtra[n] = (r >= 4) ? 1'b1 : (($urandom % 5) == 0 && !lm[f]);
                d_end[n]  = (r == rows - 1);
                d_spk[n]  = spk[f];
                e_en[n]   = (f > 0) && spk[f-1];
                e_row[n]  = ((po[f] || (lm[f] && d_xtra[n])) ? d_line[n] : d_bits[n]) & ~d_off[n];
                n++;
            end
        end
        @(negedge clk);
        rst_n = 1'b0;
        row_stb = 1'b0;
        sync_mode = mode;
        repeat (2) @(negedge clk);
        check_idle("reset");
        rst_n = 1'b1;
        for (int i = 0; i <= n; i++) begin
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                if (j < 2) begin
                    if (i == 0) check_idle("pre");
                    else check_row(i - 1, 14 + j, mode);
                end else begin
                    if (i < n) check_row(i, j - 2, mode);
                    else check_idle("post");
                end
                samp_clk = 1'($urandom);
                if (j == 0 && i < n) begin
                    row_stb   = 1'b1;
                    row_bits  = d_bits[i];
                    col_off   = d_off[i];
                    test_line = d_line[i];
                    pat_all   = d_po[i];
                    xrow_en   = d_lm[i];
                    row_xtra  = d_xtra[i];
                    row_end   = d_end[i];
                    sync_en   = d_spk[i];
                end else if (j == 1) begin
                    row_stb = 1'b0;
                    row_bits = rnd128();
                    sync_en = 1'($urandom);
                end
            end
        end
        repeat (3) begin
            @(negedge clk);
            check_idle("tail");
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        run(1'b0, 4, 8'b0101, 8'b0000, 8'b0010);
        run(1'b1, 4, 8'b1011, 8'b0001, 8'b0100);
        run(1'b0, 5, 8'b11011, 8'b01000, 8'b10001);
        run(1'b1, 3, 8'b110, 8'b010, 8'b001);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule